// File: doc/BRIEF.md
# Floating-Point Exception Trap Resolver

This block sits after the operand classifier of a floating-point unit. For each operation it takes the raw exception flags produced by the arithmetic and the five-bit trap enable mask. It also takes the hints computed by the subnormal classifier: gross underflow, gross overflow, subnormal involvement and any trap the classifier has already decided. From these it resolves one trap outcome, the final current-exception bits that software will see, and a strobe that tells the writeback path to replace the result with a zero of the same sign.

The resolution walks a fixed priority. An overflow flag is considered first, then divide-by-zero and invalid when enabled, then underflow when no subnormal operand or result was involved. Underflow and overflow outcomes rewrite the flag set. When the matching trap or the inexact trap is enabled, only the enabled condition is reported. When neither is enabled, the pair (underflow or overflow, together with inexact) is reported and no trap is taken. For divides in flush-to-zero mode that carry a subnormal operand, the block builds the flags itself from which operands were subnormal. Results are registered, so they appear one clock after the request.

Top module: `fxr_trap_resolver`

## Requirements
- R1: After a synchronous reset, out_valid, trap_type, cexc and zero_result are all 0.
- R2: Outputs appear one clock after in_valid is sampled high. out_valid follows in_valid with that delay, and on a cycle where out_valid is 0 the other outputs are all 0.
- R3: Flags use bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. trap_type encodes 0 none, 1 IEEE exception, 2 unfinished. When pend_trap is 2, trap_type is 2, cexc equals the effective flags, and zero_result is 0.
- R4: A raised overflow flag selects the overflow outcome even when enabled divide-by-zero or invalid is also present.
- R5: Otherwise, when divide-by-zero or invalid is both raised and enabled, trap_type is 1 and cexc equals the effective flags.
- R6: A raised underflow flag with subnormal involvement, no gross underflow and nothing enabled leaves trap_type 0 and cexc equal to the flags.
- R7: On the underflow outcome (gross underflow, or an underflow flag without subnormal involvement) with the underflow and inexact enables both clear, trap_type is 0 and cexc is 5'b00101. zero_result is 1 exactly when gross underflow was signalled.
- R8: On the underflow outcome with either enable set, trap_type is 1 and cexc is 5'b00100 if the underflow enable is set, else 5'b00001. A pending IEEE trap from the classifier is replaced by this outcome.
- R9: On the overflow outcome (gross overflow, or the overflow flag) with the overflow and inexact enables both clear, trap_type is 0 and cexc is 5'b01001. Otherwise trap_type is 1 and cexc is 5'b01000 if the overflow enable is set, else 5'b00001.
- R10: An enabled inexact flag with no gross underflow, no overflow outcome and no other trap gives trap_type 1 with cexc equal to the flags.
- R11: When div_flush is 1 the effective flags replace raw_flags. They are 5'b10000 if both dvd_sub and dvs_sub are set, 5'b00010 if only dvs_sub is set, and 5'b00001 otherwise.
- R12: With pend_trap 0 and a trap enable mask of 0, trap_type is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| raw_flags | input | 5 | Exception flags from the arithmetic |
| trap_en | input | 5 | Trap enable mask, same bit order |
| gross_uf | input | 1 | Classifier: gross underflow, result becomes zero |
| gross_of | input | 1 | Classifier: gross overflow result |
| subn_inv | input | 1 | Classifier: a subnormal operand or result was involved |
| pend_trap | input | 2 | Trap already decided by the classifier |
| div_flush | input | 1 | Flush-mode divide with a subnormal operand and no NaN, infinity or zero |
| dvd_sub | input | 1 | Dividend was subnormal |
| dvs_sub | input | 1 | Divisor was subnormal |
| out_valid | output | 1 | Result valid |
| trap_type | output | 2 | Resolved trap outcome |
| cexc | output | 5 | Final current-exception bits |
| zero_result | output | 1 | Replace the result with a signed zero |

## Verification
The functions that collide are priority selection and flag rewriting. An overflow flag can arrive together with enabled divide-by-zero, and a gross underflow can arrive while the classifier already holds an IEEE trap and inexact is enabled. Directed cases stack these conditions in one request. A random sweep also mixes every input on each clock. A behavioural reference in the bench judges the trap type, the rewritten flags and the zero strobe one cycle later.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  localparam int FLAG_W = 5;
  localparam int F_NV = 4;
  localparam int F_OF = 3;
  localparam int F_UF = 2;
  localparam int F_DZ = 1;
  localparam int F_NX = 0;
  localparam int TRAP_W = 2;

  typedef enum logic [TRAP_W-1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_IEEE  = 2'd1,
    TRAP_UNFIN = 2'd2
  } trap_e;

  typedef enum logic [1:0] {
    PATH_PLAIN = 2'd0,
    PATH_UFLOW = 2'd1,
    PATH_OFLOW = 2'd2
  } path_e;
endpackage

// File: rtl/fxr_flag_src.sv
module fxr_flag_src
  import fxr_pkg::*;
(
  input  logic [FLAG_W-1:0] raw_flags,
  input  logic              div_flush,
  input  logic              dvd_sub,
  input  logic              dvs_sub,
  output logic [FLAG_W-1:0] eff_flags
);
  logic [FLAG_W-1:0] flush_flags;

  always_comb begin
    flush_flags = '0;
    if (dvd_sub && dvs_sub)  flush_flags[F_NV] = 1'b1;
    else if (dvs_sub)        flush_flags[F_DZ] = 1'b1;
    else                     flush_flags[F_NX] = 1'b1;
    eff_flags = div_flush ? flush_flags : raw_flags;
  end
endmodule

// File: rtl/fxr_priority.sv
module fxr_priority
  import fxr_pkg::*;
(
  input  logic [FLAG_W-1:0] eff_flags,
  input  logic [FLAG_W-1:0] trap_en,
  input  logic              gross_uf,
  input  logic              gross_of,
  input  logic              subn_inv,
  input  trap_e             pend,
  output path_e             path,
  output trap_e             pre_trap
);
  logic [FLAG_W-1:0] armed;
  logic              ovf_sel;
  logic              ufl_sel;

  always_comb begin
    armed    = eff_flags & trap_en;
    pre_trap = pend;
    ovf_sel  = gross_of;
    ufl_sel  = 1'b0;
    path     = PATH_PLAIN;
    if (pend != TRAP_UNFIN) begin
      if (pend == TRAP_NONE) begin
        if (eff_flags[F_OF])                  ovf_sel  = 1'b1;
        else if (armed[F_DZ] || armed[F_NV])  pre_trap = TRAP_IEEE;
        else if (eff_flags[F_UF] && !subn_inv) ufl_sel = 1'b1;
      end
      if (armed[F_NX] && !gross_uf && !ovf_sel && pre_trap == TRAP_NONE)
        pre_trap = TRAP_IEEE;
      if (gross_uf || ufl_sel)  path = PATH_UFLOW;
      else if (ovf_sel)         path = PATH_OFLOW;
    end
  end
endmodule

// File: rtl/fxr_report.sv
module fxr_report
  import fxr_pkg::*;
(
  input  path_e             path,
  input  trap_e             pre_trap,
  input  logic [FLAG_W-1:0] eff_flags,
  input  logic [FLAG_W-1:0] trap_en,
  input  logic              gross_uf,
  output trap_e             trap,
  output logic [FLAG_W-1:0] cexc,
  output logic              zero
);
  always_comb begin
    trap = pre_trap;
    cexc = eff_flags;
    zero = 1'b0;
    unique case (path)
      PATH_UFLOW: begin
        zero = gross_uf;
        cexc = '0;
        if (!trap_en[F_UF] && !trap_en[F_NX]) begin
          trap       = TRAP_NONE;
          cexc[F_UF] = 1'b1;
          cexc[F_NX] = 1'b1;
        end else begin
          trap = TRAP_IEEE;
          if (trap_en[F_UF]) cexc[F_UF] = 1'b1;
          else               cexc[F_NX] = 1'b1;
        end
      end
      PATH_OFLOW: begin
        cexc = '0;
        if (!trap_en[F_OF] && !trap_en[F_NX]) begin
          trap       = TRAP_NONE;
          cexc[F_OF] = 1'b1;
          cexc[F_NX] = 1'b1;
        end else begin
          trap = TRAP_IEEE;
          if (trap_en[F_OF]) cexc[F_OF] = 1'b1;
          else               cexc[F_NX] = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fxr_trap_resolver.sv
module fxr_trap_resolver
  import fxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLAG_W-1:0] raw_flags,
  input  logic [FLAG_W-1:0] trap_en,
  input  logic              gross_uf,
  input  logic              gross_of,
  input  logic              subn_inv,
  input  logic [TRAP_W-1:0] pend_trap,
  input  logic              div_flush,
  input  logic              dvd_sub,
  input  logic              dvs_sub,
  output logic              out_valid,
  output logic [TRAP_W-1:0] trap_type,
  output logic [FLAG_W-1:0] cexc,
  output logic              zero_result
);
  logic [FLAG_W-1:0] eff_flags;
  path_e             path;
  trap_e             pre_trap;
  trap_e             fin_trap;
  logic [FLAG_W-1:0] fin_cexc;
  logic              fin_zero;

  fxr_flag_src u_src (
    .raw_flags (raw_flags),
    .div_flush (div_flush),
    .dvd_sub   (dvd_sub),
    .dvs_sub   (dvs_sub),
    .eff_flags (eff_flags)
  );

  fxr_priority u_prio (
    .eff_flags (eff_flags),
    .trap_en   (trap_en),
    .gross_uf  (gross_uf),
    .gross_of  (gross_of),
    .subn_inv  (subn_inv),
    .pend      (trap_e'(pend_trap)),
    .path      (path),
    .pre_trap  (pre_trap)
  );

  fxr_report u_rep (
    .path      (path),
    .pre_trap  (pre_trap),
    .eff_flags (eff_flags),
    .trap_en   (trap_en),
    .gross_uf  (gross_uf),
    .trap      (fin_trap),
    .cexc      (fin_cexc),
    .zero      (fin_zero)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid   <= 1'b0;
      trap_type   <= '0;
      cexc        <= '0;
      zero_result <= 1'b0;
    end else begin
      out_valid   <= 1'b1;
      trap_type   <= fin_trap;
      cexc        <= fin_cexc;
      zero_result <= fin_zero;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (trap_type == '0 && cexc == '0 && !zero_result));

  p_unfin_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pend_trap) == TRAP_UNFIN && !$past(div_flush))
    |-> (trap_type == TRAP_UNFIN && cexc == $past(raw_flags) && !zero_result));

  p_zero_gross_r7: assert property (@(posedge clk) disable iff (rst)
    zero_result |-> ($past(gross_uf) && $past(in_valid)));

  p_uf_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zero_result && trap_type == TRAP_NONE) |-> cexc == 5'b00101);

  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(trap_en) == '0 && $past(pend_trap) == TRAP_NONE)
    |-> trap_type == TRAP_NONE);
endmodule

// File: tb/fxr_trap_resolver_tb.sv
module fxr_trap_resolver_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [4:0] raw_flags = '0;
  logic [4:0] trap_en = '0;
  logic       gross_uf = 1'b0, gross_of = 1'b0, subn_inv = 1'b0;
  logic [1:0] pend_trap = '0;
  logic       div_flush = 1'b0, dvd_sub = 1'b0, dvs_sub = 1'b0;
  logic       out_valid;
  logic [1:0] trap_type;
  logic [4:0] cexc;
  logic       zero_result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fxr_trap_resolver u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_flags(raw_flags),
    .trap_en(trap_en), .gross_uf(gross_uf), .gross_of(gross_of),
    .subn_inv(subn_inv), .pend_trap(pend_trap), .div_flush(div_flush),
    .dvd_sub(dvd_sub), .dvs_sub(dvs_sub), .out_valid(out_valid),
    .trap_type(trap_type), .cexc(cexc), .zero_result(zero_result)
  );

  // Reference: returns {trap[1:0], zero, cexc[4:0]}
  function automatic logic [7:0] ref_out(input int raw, input int en,
      input bit gu, input bit go, input bit sb, input int pend,
      input bit df, input bit dd, input bit dv);
    int f;
    int e;
    int t;
    int c;
    bit z;
    bit ovf;
    bit ufl;
    f = raw;
    if (df) f = (dd && dv) ? 16 : (dv ? 2 : 1);
    e = f & en;
    z = 1'b0;
    if (pend == 2) return {2'd2, 1'b0, f[4:0]};
    t = pend; ovf = go; ufl = gu;
    if (t == 0) begin
      if ((f & 8) != 0) ovf = 1'b1;
      else if ((e & 18) != 0) t = 1;
      else if ((f & 4) != 0 && !sb) ufl = 1'b1;
    end
    if ((e & 1) != 0 && !gu && !ovf && t == 0) t = 1;
    if (ufl) begin
      z = gu;
      if ((en & 5) == 0) begin t = 0; c = 5; end
      else begin t = 1; c = ((en & 4) != 0) ? 4 : 1; end
    end else if (ovf) begin
      if ((en & 9) == 0) begin t = 0; c = 9; end
      else begin t = 1; c = ((en & 8) != 0) ? 8 : 1; end
    end else c = f;
    return {t[1:0], z, c[4:0]};
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check(input string tag, input bit ev, input logic [7:0] ep);
    logic [7:0] act;
    act = {trap_type, zero_result, cexc};
    n_chk++;
    if (out_valid !== ev || act !== ep) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b trap=%0d zero=%0b cexc=%05b expected valid=%0b trap=%0d zero=%0b cexc=%05b",
               tag, out_valid, act[7:6], act[5], act[4:0], ev, ep[7:6], ep[5], ep[4:0]);
    end
  endtask

  // Drive at a falling edge; compare at the next falling edge
  task automatic drive(input string tag, input bit v, input int raw, input int en,
      input bit gu, input bit go, input bit sb, input int pend,
      input bit df, input bit dd, input bit dv);
    logic [7:0] ep;
    in_valid = v; raw_flags = raw[4:0]; trap_en = en[4:0];
    gross_uf = gu; gross_of = go; subn_inv = sb; pend_trap = pend[1:0];
    div_flush = df; dvd_sub = dd; dvs_sub = dv;
    ep = v ? ref_out(raw, en, gu, go, sb, pend, df, dd, dv) : 8'd0;
    @(negedge clk);
    check(tag, v, ep);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 8'd0);
    rst = 1'b0;
    // R3 unfinished passes through
    drive("R3 unfinished", 1, 5'b01101, 5'b11111, 1, 1, 0, 2, 0, 0, 0);
    // R4 overflow ahead of enabled divide-by-zero
    drive("R4 ovf beats dz", 1, 5'b01011, 5'b00010, 0, 0, 0, 0, 0, 0, 0);
    drive("R4 ovf enabled", 1, 5'b01011, 5'b01010, 0, 0, 0, 0, 0, 0, 0);
    // R5 enabled dz / nv
    drive("R5 dz", 1, 5'b00011, 5'b00010, 0, 0, 0, 0, 0, 0, 0);
    drive("R5 nv", 1, 5'b10000, 5'b10000, 0, 0, 0, 0, 0, 0, 0);
    // R6 underflow with subnormal involvement
    drive("R6 subn uf", 1, 5'b00101, 5'b00000, 0, 0, 1, 0, 0, 0, 0);
    // R7 underflow outcome masked
    drive("R7 uf masked", 1, 5'b00101, 5'b00000, 0, 0, 0, 0, 0, 0, 0);
    drive("R7 gross uf zero", 1, 5'b00000, 5'b10010, 1, 0, 1, 0, 0, 0, 0);
    // R8 underflow outcome trapping, pending IEEE replaced
    drive("R8 uf en", 1, 5'b00101, 5'b00101, 0, 0, 0, 0, 0, 0, 0);
    drive("R8 nx en", 1, 5'b00101, 5'b00001, 0, 0, 0, 0, 0, 0, 0);
    drive("R8 pend cleared", 1, 5'b00001, 5'b00000, 1, 0, 0, 1, 0, 0, 0);
    drive("R8 pend gross en", 1, 5'b00001, 5'b00001, 1, 0, 0, 1, 0, 0, 0);
    // R9 overflow outcome
    drive("R9 gross of masked", 1, 5'b00000, 5'b00000, 0, 1, 0, 0, 0, 0, 0);
    drive("R9 of nx en", 1, 5'b01001, 5'b00001, 0, 0, 0, 0, 0, 0, 0);
    // R10 inexact
    drive("R10 nx", 1, 5'b00001, 5'b00001, 0, 0, 0, 0, 0, 0, 0);
    // R11 flush divide
    drive("R11 both sub", 1, 5'b00000, 5'b10000, 0, 0, 1, 0, 1, 1, 1);
    drive("R11 divisor sub", 1, 5'b11111, 5'b00010, 0, 0, 1, 0, 1, 0, 1);
    drive("R11 dividend sub", 1, 5'b00000, 5'b00001, 0, 0, 1, 0, 1, 1, 0);
    // R12 nothing enabled
    drive("R12 masked", 1, 5'b11011, 5'b00000, 0, 0, 1, 0, 0, 0, 0);
    // R2 idle cycle
    drive("R2 idle", 0, 5'b11111, 5'b11111, 1, 1, 1, 1, 0, 0, 0);
    // R2 random mix compared every clock
    for (int k = 0; k < 400; k++) begin
      drive("R2 random", bit'($urandom_range(0, 3) != 0),
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)));
    end
    finish_up();
  end
endmodule